// File: doc/BRIEF.md
# Multiplexed 4:2:2 Component Stream Splitter

This block receives a 10-bit component video stream in which chroma and luma share one word lane at twice the pixel rate. The word order inside each two-pixel group is blue difference, first luma, red difference, second luma. The blue and red samples are cosited with the first luma of the group. The block finds the start of a group in one of two ways. It can watch for the embedded timing reference words. It can also watch for a falling edge on an external active-low horizontal sync strobe. It then splits the lane into separate luma and chroma samples.

Two optional corrections run on the samples. The first removes the blanking level from luma, saturating at zero. The second inverts the top bit of both colour-difference samples. The output is one luma/blue/red triple per pixel-enable pulse, at half the word rate. Chroma is filled in for the second pixel of each group as the rounded mean of the two cosited neighbours. In embedded-timing mode the field and vertical-blanking flags are taken from every timing reference word seen.

Top module: `ycc_demux`

## Requirements
- R1: While `rst` is high at a rising clock edge, every register is cleared. After reset, `pix_en`, `y_out`, `cb_out`, `cr_out`, `f_flag` and `v_flag` read zero until a pixel is emitted or a timing reference is seen.
- R2: With `sync_ext` low, a timing reference is the word sequence 0x3FF, 0x000, 0x000, then a word with bit 9 set. If bit 6 of that last word is 0 (start of active video), the next word is taken as the blue-difference sample of a new group.
- R3: With `sync_ext` high, a falling edge of `hsync_n` realigns the groups. The falling edge means one clock sampled it high and the next clock sampled it low. The word after the low sample is taken as the blue-difference sample of a new group. Timing reference words do not realign the groups in this mode.
- R4: With `sync_ext` low, each timing reference (bit 6 of the last word 0 or 1) loads `f_flag` from bit 8 and `v_flag` from bit 7 of its last word. The flags hold otherwise. A reference with bit 6 = 1 (end of active video) does not realign the groups.
- R5: With `luma_ofs_en` high, 64 is subtracted from each luma sample, and a sample below 64 gives 0. With `luma_ofs_en` low, luma passes unchanged.
- R6: With `chroma_inv` high, bit 9 of each blue and red sample is inverted. With `chroma_inv` low, both samples pass unchanged.
- R7: `pix_en` pulses for one clock, one clock after the first luma word of a group is captured. It then carries the previous group's first pixel: its first luma, blue and red. It pulses again one clock after the second luma word is captured. `pix_en` is never high on two clocks in a row.
- R8: The pulse after a second luma word carries the previous group's second luma. Its blue value is (Cb_prev + Cb_cur + 1) >> 1 and its red value is (Cr_prev + Cr_cur + 1) >> 1, using the samples after the R6 correction.
- R9: Without a realignment event the group position advances by one word per clock through blue, first luma, red, second luma, and then wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock, twice the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 10 | Multiplexed component word |
| sync_ext | input | 1 | 1: align on `hsync_n` edge; 0: align on embedded timing reference |
| luma_ofs_en | input | 1 | Remove the 64-code blanking level from luma |
| chroma_inv | input | 1 | Invert bit 9 of blue and red samples |
| hsync_n | input | 1 | External active-low horizontal sync strobe |
| pix_en | output | 1 | One-clock pixel strobe |
| y_out | output | 10 | Luma of the emitted pixel |
| cb_out | output | 10 | Blue difference of the emitted pixel |
| cr_out | output | 10 | Red difference of the emitted pixel |
| f_flag | output | 1 | Field bit of the last timing reference |
| v_flag | output | 1 | Vertical-blanking bit of the last timing reference |

## Verification
The properties take for granted that `din`, `hsync_n` and the mode controls are known values, sampled once per word. `sync_ext` may change between words, and the properties read it on the same edge as the word it governs. The stimulus changes every input only midway between clock edges. It switches modes only between random segments, and it inserts timing references as four whole words. Random data may still form a reference by chance, and the reference model scores that case by the same rules.

// File: rtl/ycc_demux_pkg.sv
package ycc_demux_pkg;

    localparam int unsigned DW     = 10;
    localparam int unsigned PH_W   = 2;
    localparam int unsigned F_POS  = 8;
    localparam int unsigned V_POS  = 7;
    localparam int unsigned H_POS  = 6;
    localparam int unsigned HIST_N = 3;

    typedef logic [DW-1:0] word_t;

    typedef enum logic [PH_W-1:0] {
        PH_CB = 2'd0,
        PH_YA = 2'd1,
        PH_CR = 2'd2,
        PH_YB = 2'd3
    } phase_e;

    typedef struct packed {
        word_t y;
        word_t cb;
        word_t cr;
    } pix_t;

    localparam word_t TRS_HEAD   = '1;
    localparam word_t TRS_ZERO   = '0;
    localparam word_t CHROMA_MSB = word_t'(1) << (DW - 1);
    localparam word_t LUMA_BLANK = word_t'(64);

    function automatic word_t luma_strip(word_t s, logic en, word_t lvl);
        if (!en)
            return s;
        if (s < lvl)
            return '0;
        return s - lvl;
    endfunction

    function automatic word_t chroma_fix(word_t s, logic inv);
        return inv ? (s ^ CHROMA_MSB) : s;
    endfunction

    function automatic word_t avg_round(word_t a, word_t b);
        logic [DW:0] sum;
        sum = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, 1'b1};
        return sum[DW:1];
    endfunction

    function automatic phase_e phase_step(phase_e p);
        logic [PH_W-1:0] t;
        t = p;
        t = t + 2'd1;
        return phase_e'(t);
    endfunction

endpackage

// File: rtl/ycc_trs_detect.sv
module ycc_trs_detect
    import ycc_demux_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t din,
    input  logic  capture_en,
    output logic  trs_hit,
    output logic  sav_hit,
    output logic  f_flag,
    output logic  v_flag
);

    word_t hist [HIST_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HIST_N; i++)
                hist[i] <= '0;
        end else begin
            hist[0] <= din;
            for (int i = 1; i < HIST_N; i++)
                hist[i] <= hist[i-1];
        end
    end

    always_comb begin
        trs_hit = (hist[2] == TRS_HEAD) && (hist[1] == TRS_ZERO) &&
                  (hist[0] == TRS_ZERO) && din[DW-1];
        sav_hit = trs_hit && !din[H_POS];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_flag <= 1'b0;
            v_flag <= 1'b0;
        end else if (capture_en && trs_hit) begin
            f_flag <= din[F_POS];
            v_flag <= din[V_POS];
        end
    end

endmodule

// File: rtl/ycc_phase_track.sv
module ycc_phase_track
    import ycc_demux_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sync_ext,
    input  logic   sav_hit,
    input  logic   hsync_n,
    output phase_e ph_q,
    output logic   align
);

    logic hs_q;

    always_ff @(posedge clk) begin
        hs_q <= hsync_n;
    end

    always_comb begin
        if (sync_ext)
            align = hs_q && !hsync_n;
        else
            align = sav_hit;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ph_q <= PH_CB;
        else if (align)
            ph_q <= PH_CB;
        else
            ph_q <= phase_step(ph_q);
    end

endmodule

// File: rtl/ycc_pixel_build.sv
module ycc_pixel_build
    import ycc_demux_pkg::*;
#(
    parameter word_t BLANK = LUMA_BLANK
) (
    input  logic   clk,
    input  logic   rst,
    input  word_t  din,
    input  phase_e ph,
    input  logic   luma_ofs_en,
    input  logic   chroma_inv,
    output logic   pix_en,
    output pix_t   pix
);

    word_t chroma_w;
    word_t luma_w;
    word_t cb_hold, cr_hold;
    word_t cb_prev, cr_prev;
    word_t ya_hold, yb_prev;

    always_comb begin
        chroma_w = chroma_fix(din, chroma_inv);
        luma_w   = luma_strip(din, luma_ofs_en, BLANK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cb_hold <= '0;
            cr_hold <= '0;
            cb_prev <= '0;
            cr_prev <= '0;
            ya_hold <= '0;
            yb_prev <= '0;
            pix     <= '0;
            pix_en  <= 1'b0;
        end else begin
            pix_en <= 1'b0;
            unique case (ph)
                PH_CB: cb_hold <= chroma_w;
                PH_YA: begin
                    pix     <= '{y: ya_hold, cb: cb_prev, cr: cr_prev};
                    pix_en  <= 1'b1;
                    ya_hold <= luma_w;
                end
                PH_CR: cr_hold <= chroma_w;
                PH_YB: begin
                    pix     <= '{y:  yb_prev,
                                 cb: avg_round(cb_prev, cb_hold),
                                 cr: avg_round(cr_prev, cr_hold)};
                    pix_en  <= 1'b1;
                    cb_prev <= cb_hold;
                    cr_prev <= cr_hold;
                    yb_prev <= luma_w;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ycc_demux.sv
module ycc_demux
    import ycc_demux_pkg::*;
#(
    parameter word_t BLANK_LEVEL = LUMA_BLANK
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] din,
    input  logic          sync_ext,
    input  logic          luma_ofs_en,
    input  logic          chroma_inv,
    input  logic          hsync_n,
    output logic          pix_en,
    output logic [DW-1:0] y_out,
    output logic [DW-1:0] cb_out,
    output logic [DW-1:0] cr_out,
    output logic          f_flag,
    output logic          v_flag
);

    logic   trs_hit;
    logic   sav_hit;
    logic   align;
    phase_e ph_q;
    pix_t   pix;

    ycc_trs_detect u_trs (
        .clk        (clk),
        .rst        (rst),
        .din        (din),
        .capture_en (!sync_ext),
        .trs_hit    (trs_hit),
        .sav_hit    (sav_hit),
        .f_flag     (f_flag),
        .v_flag     (v_flag)
    );

    ycc_phase_track u_phase (
        .clk      (clk),
        .rst      (rst),
        .sync_ext (sync_ext),
        .sav_hit  (sav_hit),
        .hsync_n  (hsync_n),
        .ph_q     (ph_q),
        .align    (align)
    );

    ycc_pixel_build #(.BLANK(BLANK_LEVEL)) u_build (
        .clk         (clk),
        .rst         (rst),
        .din         (din),
        .ph          (ph_q),
        .luma_ofs_en (luma_ofs_en),
        .chroma_inv  (chroma_inv),
        .pix_en      (pix_en),
        .pix         (pix)
    );

    assign y_out  = pix.y;
    assign cb_out = pix.cb;
    assign cr_out = pix.cr;

endmodule

// File: rtl/ycc_demux_chk.sv
module ycc_demux_chk (
    input logic       clk,
    input logic       rst,
    input logic       sync_ext,
    input logic       hsync_n,
    input logic       trs_hit,
    input logic       din_f,
    input logic       din_v,
    input logic       din_h,
    input logic       f_flag,
    input logic       v_flag,
    input logic       pix_en,
    input logic [1:0] ph,
    input logic       align
);

    // R7: pixel strobe never on two consecutive clocks
    a_r7_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        pix_en |=> !pix_en);

    // R2: start-of-active reference puts the next word at blue position
    a_r2_sav_aligns: assert property (@(posedge clk) disable iff (rst)
        (!sync_ext && trs_hit && !din_h) |=> (ph == 2'd0));

    // R3: sync strobe falling edge realigns groups
    a_r3_hsync_aligns: assert property (@(posedge clk) disable iff (rst)
        (sync_ext && $past(hsync_n) && !hsync_n) |=> (ph == 2'd0));

    // R4: flags loaded from the reference word
    a_r4_flags_load: assert property (@(posedge clk) disable iff (rst)
        (!sync_ext && trs_hit) |=> (f_flag == $past(din_f) && v_flag == $past(din_v)));

    // R4: flags hold without a reference
    a_r4_flags_hold: assert property (@(posedge clk) disable iff (rst)
        !(!sync_ext && trs_hit) |=> ($stable(f_flag) && $stable(v_flag)));

    // R9: free-running position advance
    a_r9_free_run: assert property (@(posedge clk) disable iff (rst)
        !align |=> (ph == $past(ph) + 2'd1));

endmodule

bind ycc_demux ycc_demux_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .sync_ext (sync_ext),
    .hsync_n  (hsync_n),
    .trs_hit  (trs_hit),
    .din_f    (din[8]),
    .din_v    (din[7]),
    .din_h    (din[6]),
    .f_flag   (f_flag),
    .v_flag   (v_flag),
    .pix_en   (pix_en),
    .ph       (ph_q),
    .align    (align)
);

// File: tb/test_ycc_demux.sv
`timescale 1ns/1ps
module test_ycc_demux;

    logic       clk = 1'b0;
    logic       rst;
    logic [9:0] din;
    logic       sync_ext, luma_ofs_en, chroma_inv, hsync_n;
    logic       pix_en, f_flag, v_flag;
    logic [9:0] y_out, cb_out, cr_out;

    always #2.5 clk = ~clk;

    ycc_demux i_ycc_demux (
        .clk(clk), .rst(rst), .din(din), .sync_ext(sync_ext),
        .luma_ofs_en(luma_ofs_en), .chroma_inv(chroma_inv), .hsync_n(hsync_n),
        .pix_en(pix_en), .y_out(y_out), .cb_out(cb_out), .cr_out(cr_out),
        .f_flag(f_flag), .v_flag(v_flag)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model state
    logic [1:0] m_ph;
    logic [9:0] m_cbh, m_crh, m_ya, m_cbp, m_crp, m_ybp;
    logic [9:0] m_h0, m_h1, m_h2;
    logic       m_hs;
    logic       e_en, e_f, e_v;
    logic [9:0] e_y, e_cb, e_cr;

    function automatic logic [9:0] ref_luma(logic [9:0] s, logic en);
        if (!en) return s;
        return (s < 10'd64) ? 10'd0 : s - 10'd64;
    endfunction

    function automatic logic [9:0] ref_chroma(logic [9:0] s, logic inv);
        return {s[9] ^ inv, s[8:0]};
    endfunction

    function automatic logic [9:0] ref_avg(logic [9:0] a, logic [9:0] b);
        int s;
        s = (int'(a) + int'(b) + 1) / 2;
        return 10'(s);
    endfunction

    task automatic chk(string tag, string what, logic [9:0] act, logic [9:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_model(string tag);
        chk(tag, "pix_en", {9'd0, pix_en}, {9'd0, e_en});
        chk(tag, "y_out", y_out, e_y);
        chk(tag, "cb_out", cb_out, e_cb);
        chk(tag, "cr_out", cr_out, e_cr);
        chk(tag, "f_flag", {9'd0, f_flag}, {9'd0, e_f});
        chk(tag, "v_flag", {9'd0, v_flag}, {9'd0, e_v});
    endtask

    task automatic model_reset();
        m_ph = 0; m_cbh = 0; m_crh = 0; m_ya = 0; m_cbp = 0; m_crp = 0; m_ybp = 0;
        m_h0 = 0; m_h1 = 0; m_h2 = 0; m_hs = 1;
        e_en = 0; e_f = 0; e_v = 0; e_y = 0; e_cb = 0; e_cr = 0;
    endtask

    task automatic model_step(logic [9:0] w, logic hs);
        logic trs, al;
        e_en = 0;
        case (m_ph)
            2'd0: m_cbh = ref_chroma(w, chroma_inv);
            2'd1: begin
                e_en = 1; e_y = m_ya; e_cb = m_cbp; e_cr = m_crp;
                m_ya = ref_luma(w, luma_ofs_en);
            end
            2'd2: m_crh = ref_chroma(w, chroma_inv);
            default: begin
                e_en = 1; e_y = m_ybp;
                e_cb = ref_avg(m_cbp, m_cbh); e_cr = ref_avg(m_crp, m_crh);
                m_cbp = m_cbh; m_crp = m_crh; m_ybp = ref_luma(w, luma_ofs_en);
            end
        endcase
        trs = (m_h2 == 10'h3FF) && (m_h1 == 0) && (m_h0 == 0) && w[9];
        if (!sync_ext && trs) begin e_f = w[8]; e_v = w[7]; end
        al = sync_ext ? (m_hs && !hs) : (trs && !w[6]);
        m_ph = al ? 2'd0 : m_ph + 2'd1;
        m_h2 = m_h1; m_h1 = m_h0; m_h0 = w; m_hs = hs;
    endtask

    task automatic push(logic [9:0] w, logic hs, string tag);
        compare_model(tag);
        model_step(w, hs);
        din = w;
        hsync_n = hs;
        @(negedge clk);
    endtask

    task automatic push_trs(logic f, logic v, logic h, string tag);
        push(10'h3FF, 1'b1, tag);
        push(10'h000, 1'b1, tag);
        push(10'h000, 1'b1, tag);
        push({1'b1, f, v, h, 6'h05}, 1'b1, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual run still active, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        rst = 1; din = 0; hsync_n = 1; sync_ext = 0; luma_ofs_en = 0; chroma_inv = 0;
        model_reset();
        repeat (4) @(negedge clk);
        rst = 0;

        // R1: reset state
        chk("R1", "pix_en", {9'd0, pix_en}, 10'd0);
        chk("R1", "y_out", y_out, 10'd0);
        chk("R1", "cb_out", cb_out, 10'd0);
        chk("R1", "cr_out", cr_out, 10'd0);
        chk("R1", "f_flag", {9'd0, f_flag}, 10'd0);
        chk("R1", "v_flag", {9'd0, v_flag}, 10'd0);

        // Directed A: start-of-active alignment, luma offset, interpolation
        luma_ofs_en = 1;
        push_trs(1'b0, 1'b0, 1'b0, "R2 R4");
        chk("R4", "f_flag", {9'd0, f_flag}, 10'd0);
        push(10'd100, 1, "R2"); push(10'd30, 1, "R5"); push(10'd300, 1, "R2");
        push(10'd500, 1, "R5"); push(10'd201, 1, "R8"); push(10'd64, 1, "R5");
        chk("R7", "pix_en even", {9'd0, pix_en}, 10'd1);
        chk("R5", "y_out saturate", y_out, 10'd0);
        chk("R2", "cb_out", cb_out, 10'd100);
        chk("R2", "cr_out", cr_out, 10'd300);
        push(10'd401, 1, "R8");
        chk("R7", "pix_en gap", {9'd0, pix_en}, 10'd0);
        push(10'd70, 1, "R8");
        chk("R5", "y_out minus 64", y_out, 10'd436);
        chk("R8", "cb_out mean", cb_out, 10'd151);
        chk("R8", "cr_out mean", cr_out, 10'd351);

        // Directed B: end-of-active flags, chroma inversion
        luma_ofs_en = 0; chroma_inv = 1;
        push_trs(1'b1, 1'b1, 1'b1, "R4");
        chk("R4", "f_flag eav", {9'd0, f_flag}, 10'd1);
        chk("R4", "v_flag eav", {9'd0, v_flag}, 10'd1);
        push_trs(1'b1, 1'b0, 1'b0, "R4");
        chk("R4", "v_flag sav", {9'd0, v_flag}, 10'd0);
        push(10'h100, 1, "R6"); push(10'h123, 1, "R6"); push(10'h050, 1, "R6");
        push(10'h007, 1, "R6"); push(10'h000, 1, "R6"); push(10'h000, 1, "R6");
        chk("R6", "cb_out inverted", cb_out, 10'h300);
        chk("R6", "cr_out inverted", cr_out, 10'h250);
        chk("R6", "y_out", y_out, 10'h123);

        // Directed C: external sync alignment, then free run
        chroma_inv = 0; sync_ext = 1;
        push(10'd5, 1, "R3"); push(10'd6, 1, "R3"); push(10'd7, 0, "R3");
        push(10'd10, 0, "R3"); push(10'd20, 0, "R3"); push(10'd30, 0, "R3");
        push(10'd40, 0, "R3"); push(10'd50, 0, "R3"); push(10'd60, 0, "R3");
        chk("R3", "y_out", y_out, 10'd20);
        chk("R3", "cb_out", cb_out, 10'd10);
        chk("R3", "cr_out", cr_out, 10'd30);
        push(10'd70, 0, "R9"); push(10'd80, 0, "R9");
        push(10'd90, 0, "R9"); push(10'd100, 0, "R9");
        chk("R9", "y_out", y_out, 10'd60);
        chk("R9", "cb_out", cb_out, 10'd50);
        chk("R9", "cr_out", cr_out, 10'd70);

        // Random segments against the model
        for (int s = 0; s < 16; s++) begin
            sync_ext    = $urandom % 2;
            luma_ofs_en = $urandom % 2;
            chroma_inv  = $urandom % 2;
            for (int k = 0; k < 250; k++) begin
                if (!sync_ext && ($urandom % 40 == 0))
                    push_trs($urandom % 2, $urandom % 2, $urandom % 2, "R2 R4 R9");
                else
                    push(10'($urandom % 1024), sync_ext ? ($urandom % 12 != 0) : 1'b1,
                         "R3 R5 R6 R7 R8 R9");
            end
        end
        compare_model("R7 R8");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule